// File: doc/BRIEF.md
# Descriptor Channel Control and Status Register Block

This block is the software-visible register front end of a single descriptor-driven transfer channel. The channel may be a copy channel or an XOR channel. A 32-bit register port addressed by byte offset reaches four registers. The control register holds the channel enable, a chain-resume request and three interrupt enables. The status register holds a live busy flag and sticky event flags. A read-only view shows the descriptor the engine is currently working on. A read/write register holds the next descriptor address for the engine.

The channel engine drives a busy level, a current-descriptor value and single-cycle event strobes: end of transfer, end of chain and four error kinds. The block latches each event into a sticky status bit, and software clears that bit by writing a one to its position. Writing the resume bit sends the engine a one-cycle pulse. The engine then rereads the next-descriptor pointer, so a chain that has already gone idle continues with the descriptors appended since. An interrupt line summarises the enabled sticky flags. A parameter selects the XOR variant, which records only the internal master abort error.

Top module: `chan_csr_regs`

## Requirements
- R1: After reset the control, status and next-descriptor registers read zero, and chan_en, chan_resume and irq are low.
- R2: Writing offset 0x0 loads bit 0 into the channel enable. The new value drives chan_en from the clock edge that takes the write and reads back at bit 0. Clearing the bit disables the channel.
- R3: Writing a 1 to control bit 1 raises chan_resume for exactly one clock cycle, starting at the clock edge that takes the write. Bit 1 always reads back as 0.
- R4: The resume pulse is issued only when the same control write also sets bit 0. A resume write with bit 0 clear produces no pulse.
- R5: Offset 0x10 is a read/write next-descriptor register that drives next_desc.
- R6: Offset 0xC reads the engine's current descriptor address, and writes to that offset have no effect.
- R7: Status bit 10 follows eng_busy, and writes to it have no effect.
- R8: Status bit 9 (end of transfer) and bit 8 (end of chain) are set by their engine strobes and stay set. Each is cleared only by writing 1 to its position at offset 0x4. Writing 0 leaves it unchanged.
- R9: In the copy variant, the sticky error bits take eng_err[0] to bit 1 (split transaction), eng_err[1] to bit 2 (bus target abort), eng_err[2] to bit 3 (bus master abort) and eng_err[3] to bit 5 (internal master abort). In the XOR variant only bit 5 is recorded, and eng_err[2:0] are ignored. Error bits are cleared by writing one to them.
- R10: When an engine set and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R11: Control bits 2, 3 and 4 enable the interrupt for end of transfer, end of chain and any error respectively. irq is high while any enabled sticky bit is set.
- R12: Reads from any offset other than 0x0, 0x4, 0xC or 0x10 return zero, and writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| eng_busy | input | 1 | Engine busy level |
| eng_eot | input | 1 | End-of-transfer strobe |
| eng_eoc | input | 1 | End-of-chain strobe |
| eng_err | input | 4 | Error strobes: split, target abort, master abort, internal master abort |
| eng_cur_desc | input | DESC_W | Descriptor address the engine is working on |
| chan_en | output | 1 | Channel enable |
| chan_resume | output | 1 | One-cycle chain-resume pulse |
| next_desc | output | DESC_W | Next descriptor address |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a register value is due as soon as the address settles. A write or an engine strobe appears in register state, in chan_en, in chan_resume and in irq right after the single clock edge that takes it. chan_resume falls again at the following edge. Each task drives its stimulus just after one edge and lets the next edge capture it. It then samples one nanosecond after that edge for the pulse, and one clock later for its disappearance. A copy instance and an XOR instance share all stimulus, so the differing error masks are compared on the same cycle.

// File: rtl/chan_csr_pkg.sv
package chan_csr_pkg;
   localparam int CSR_W   = 32;
   localparam int ERR_NUM = 4;

   localparam int OFS_CTRL = 'h0;
   localparam int OFS_STAT = 'h4;
   localparam int OFS_CUR  = 'hC;
   localparam int OFS_NEXT = 'h10;

   localparam int CB_EN     = 0;
   localparam int CB_RESUME = 1;
   localparam int CB_IE_EOT = 2;
   localparam int CB_IE_EOC = 3;
   localparam int CB_IE_ERR = 4;

   localparam int SB_BUSY = 10;
   localparam int SB_EOT  = 9;
   localparam int SB_EOC  = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_CUR,
      SEL_NEXT
   } csr_sel_e;

   // status bit position of each engine error strobe
   function automatic int err_pos(input int idx);
      case (idx)
         0:       return 1;
         1:       return 2;
         2:       return 3;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/chan_csr_decode.sv
module chan_csr_decode
   import chan_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output csr_sel_e          sel
);
   always_comb begin
      if (addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (addr == ADDR_W'(OFS_CUR))  sel = SEL_CUR;
      else if (addr == ADDR_W'(OFS_NEXT)) sel = SEL_NEXT;
      else                                sel = SEL_NONE;
   end
endmodule

// File: rtl/chan_csr_ctrl.sv
module chan_csr_ctrl #(
   parameter int DESC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_next,
   input  logic              w_en,
   input  logic              w_resume,
   input  logic              w_ie_eot,
   input  logic              w_ie_eoc,
   input  logic              w_ie_err,
   input  logic [DESC_W-1:0] w_desc,
   output logic              en_q,
   output logic              ie_eot_q,
   output logic              ie_eoc_q,
   output logic              ie_err_q,
   output logic              resume_q,
   output logic [DESC_W-1:0] next_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ie_eot_q <= 1'b0;
         ie_eoc_q <= 1'b0;
         ie_err_q <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         resume_q <= wr_ctrl && w_resume && w_en;
         if (wr_ctrl) begin
            en_q     <= w_en;
            ie_eot_q <= w_ie_eot;
            ie_eoc_q <= w_ie_eoc;
            ie_err_q <= w_ie_err;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       next_q <= '0;
      else if (wr_next) next_q <= w_desc;
   end
endmodule

// File: rtl/chan_csr_status.sv
module chan_csr_status
   import chan_csr_pkg::*;
#(
   parameter bit XOR_MODE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_eot,
   input  logic               set_eoc,
   input  logic [ERR_NUM-1:0] set_err,
   input  logic               clr_eot,
   input  logic               clr_eoc,
   input  logic [ERR_NUM-1:0] clr_err,
   input  logic               ie_eot,
   input  logic               ie_eoc,
   input  logic               ie_err,
   output logic               eot_q,
   output logic               eoc_q,
   output logic [ERR_NUM-1:0] err_q,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eot_q <= 1'b0;
      else if (set_eot) eot_q <= 1'b1;
      else if (clr_eot) eot_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       eoc_q <= 1'b0;
      else if (set_eoc) eoc_q <= 1'b1;
      else if (clr_eoc) eoc_q <= 1'b0;
   end

   for (genvar i = 0; i < ERR_NUM; i++) begin : g_err
      if (XOR_MODE && (i != ERR_NUM-1)) begin : g_absent
         assign err_q[i] = 1'b0;
      end else begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          err_q[i] <= 1'b0;
            else if (set_err[i]) err_q[i] <= 1'b1;
            else if (clr_err[i]) err_q[i] <= 1'b0;
         end
      end
   end

   assign irq = (eot_q & ie_eot) | (eoc_q & ie_eoc) | ((|err_q) & ie_err);
endmodule

// File: rtl/chan_csr_regs.sv
module chan_csr_regs
   import chan_csr_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DESC_W   = 32,
   parameter bit XOR_MODE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_wr,
   input  logic [ADDR_W-1:0]  csr_addr,
   input  logic [CSR_W-1:0]   csr_wdata,
   output logic [CSR_W-1:0]   csr_rdata,
   input  logic               eng_busy,
   input  logic               eng_eot,
   input  logic               eng_eoc,
   input  logic [ERR_NUM-1:0] eng_err,
   input  logic [DESC_W-1:0]  eng_cur_desc,
   output logic               chan_en,
   output logic               chan_resume,
   output logic [DESC_W-1:0]  next_desc,
   output logic               irq
);
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("chan_csr_regs: ADDR_W must lie in 5..16");
   end
   if (DESC_W < 1 || DESC_W > CSR_W) begin : g_bad_desc
      $error("chan_csr_regs: DESC_W must lie in 1..32");
   end

   csr_sel_e           sel;
   logic               ie_eot, ie_eoc, ie_err;
   logic               eot_q, eoc_q;
   logic [ERR_NUM-1:0] err_q;
   logic [ERR_NUM-1:0] clr_err;
   logic               wr_stat;

   chan_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (csr_addr),
      .sel  (sel)
   );

   chan_csr_ctrl #(.DESC_W(DESC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (csr_wr && sel == SEL_CTRL),
      .wr_next  (csr_wr && sel == SEL_NEXT),
      .w_en     (csr_wdata[CB_EN]),
      .w_resume (csr_wdata[CB_RESUME]),
      .w_ie_eot (csr_wdata[CB_IE_EOT]),
      .w_ie_eoc (csr_wdata[CB_IE_EOC]),
      .w_ie_err (csr_wdata[CB_IE_ERR]),
      .w_desc   (csr_wdata[DESC_W-1:0]),
      .en_q     (chan_en),
      .ie_eot_q (ie_eot),
      .ie_eoc_q (ie_eoc),
      .ie_err_q (ie_err),
      .resume_q (chan_resume),
      .next_q   (next_desc)
   );

   assign wr_stat = csr_wr && sel == SEL_STAT;

   for (genvar i = 0; i < ERR_NUM; i++) begin : g_clr
      localparam int POS = err_pos(i);
      assign clr_err[i] = wr_stat && csr_wdata[POS];
   end

   chan_csr_status #(.XOR_MODE(XOR_MODE)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_eot (eng_eot),
      .set_eoc (eng_eoc),
      .set_err (eng_err),
      .clr_eot (wr_stat && csr_wdata[SB_EOT]),
      .clr_eoc (wr_stat && csr_wdata[SB_EOC]),
      .clr_err (clr_err),
      .ie_eot  (ie_eot),
      .ie_eoc  (ie_eoc),
      .ie_err  (ie_err),
      .eot_q   (eot_q),
      .eoc_q   (eoc_q),
      .err_q   (err_q),
      .irq     (irq)
   );

   logic [CSR_W-1:0] stat_word;
   always_comb begin
      stat_word          = '0;
      stat_word[SB_BUSY] = eng_busy;
      stat_word[SB_EOT]  = eot_q;
      stat_word[SB_EOC]  = eoc_q;
      for (int i = 0; i < ERR_NUM; i++) stat_word[err_pos(i)] = err_q[i];
   end

   logic [CSR_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word            = '0;
      ctrl_word[CB_EN]     = chan_en;
      ctrl_word[CB_IE_EOT] = ie_eot;
      ctrl_word[CB_IE_EOC] = ie_eoc;
      ctrl_word[CB_IE_ERR] = ie_err;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: csr_rdata = ctrl_word;
         SEL_STAT: csr_rdata = stat_word;
         SEL_CUR:  csr_rdata = CSR_W'(eng_cur_desc);
         SEL_NEXT: csr_rdata = CSR_W'(next_desc);
         default:  csr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/chan_csr_chk.sv
module chan_csr_chk
   import chan_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_wr,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [CSR_W-1:0]  csr_wdata,
   input logic              eng_eot,
   input logic              chan_en,
   input logic              chan_resume,
   input logic              irq,
   input logic              stat_eot,
   input logic              stat_any
);
   logic wr_ctrl, wr_stat;
   assign wr_ctrl = csr_wr && csr_addr == ADDR_W'(OFS_CTRL);
   assign wr_stat = csr_wr && csr_addr == ADDR_W'(OFS_STAT);

   a_r2_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> chan_en == $past(csr_wdata[CB_EN]));

   a_r3_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
      chan_resume |=> !chan_resume);

   a_r4_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
      chan_resume |-> $past(wr_ctrl && csr_wdata[CB_RESUME] && csr_wdata[CB_EN]));

   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && csr_wdata[SB_EOT] && !eng_eot) |=> !stat_eot);

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      eng_eot |=> stat_eot);

   a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_any);
endmodule

bind chan_csr_regs chan_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_wr      (csr_wr),
   .csr_addr    (csr_addr),
   .csr_wdata   (csr_wdata),
   .eng_eot     (eng_eot),
   .chan_en     (chan_en),
   .chan_resume (chan_resume),
   .irq         (irq),
   .stat_eot    (eot_q),
   .stat_any    (eot_q | eoc_q | (|err_q))
);

// File: tb/chan_csr_regs_tb.sv
module chan_csr_regs_tb;
   localparam int AW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [AW-1:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] rdata_c, rdata_x;
   logic        eng_busy = 1'b0, eng_eot = 1'b0, eng_eoc = 1'b0;
   logic [3:0]  eng_err = '0;
   logic [31:0] eng_cur_desc = '0;
   logic        en_c, en_x, res_c, res_x, irq_c, irq_x;
   logic [31:0] nd_c, nd_x;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chan_csr_regs #(.ADDR_W(AW), .DESC_W(32), .XOR_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata_c), .eng_busy(eng_busy),
      .eng_eot(eng_eot), .eng_eoc(eng_eoc), .eng_err(eng_err),
      .eng_cur_desc(eng_cur_desc), .chan_en(en_c), .chan_resume(res_c),
      .next_desc(nd_c), .irq(irq_c)
   );

   chan_csr_regs #(.ADDR_W(AW), .DESC_W(32), .XOR_MODE(1'b1)) u_dut_x (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata_x), .eng_busy(eng_busy),
      .eng_eot(eng_eot), .eng_eoc(eng_eoc), .eng_err(eng_err),
      .eng_cur_desc(eng_cur_desc), .chan_en(en_x), .chan_resume(res_x),
      .next_desc(nd_x), .irq(irq_x)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(posedge clk); #1;
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] dc, output logic [31:0] dx);
      @(negedge clk);
      csr_addr = a; #1;
      dc = rdata_c; dx = rdata_x;
   endtask

   task automatic pulse(input logic eot, input logic eoc, input logic [3:0] err);
      @(negedge clk);
      eng_eot = eot; eng_eoc = eoc; eng_err = err;
      @(posedge clk); #1;
      eng_eot = 1'b0; eng_eoc = 1'b0; eng_err = '0;
   endtask

   task automatic t_reset;
      logic [31:0] c, x;
      rd(8'h00, c, x); check("R1 ctrl", c, 32'h0);
      rd(8'h04, c, x); check("R1 status", c, 32'h0);
      rd(8'h10, c, x); check("R1 next", c, 32'h0);
      check("R1 outputs", {29'h0, en_c, res_c, irq_c}, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] c, x;
      wr(8'h00, 32'h1);
      check("R2 chan_en set", {31'h0, en_c}, 32'h1);
      rd(8'h00, c, x); check("R2 ctrl readback", c, 32'h1);
      wr(8'h00, 32'h0);
      check("R2 chan_en cleared", {31'h0, en_c}, 32'h0);
   endtask

   task automatic t_resume;
      logic [31:0] c, x;
      wr(8'h00, 32'h3);
      check("R3 resume high", {31'h0, res_c}, 32'h1);
      @(posedge clk); #1;
      check("R3 resume one cycle", {31'h0, res_c}, 32'h0);
      rd(8'h00, c, x); check("R3 resume reads zero", c, 32'h1);
      wr(8'h00, 32'h2);
      check("R4 no pulse when disabled", {30'h0, res_c, en_c}, 32'h0);
   endtask

   task automatic t_desc;
      logic [31:0] c, x;
      wr(8'h10, 32'hCAFE_0040);
      check("R5 next_desc port", nd_c, 32'hCAFE_0040);
      rd(8'h10, c, x); check("R5 next readback", c, 32'hCAFE_0040);
      eng_cur_desc = 32'h1234_5680;
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, c, x); check("R6 current desc view", c, 32'h1234_5680);
      check("R6 write to current ignored", nd_c, 32'hCAFE_0040);
   endtask

   task automatic t_busy;
      logic [31:0] c, x;
      eng_busy = 1'b1;
      rd(8'h04, c, x); check("R7 busy reads", c, 32'h400);
      wr(8'h04, 32'h400);
      rd(8'h04, c, x); check("R7 busy write ignored", c, 32'h400);
      eng_busy = 1'b0;
      rd(8'h04, c, x); check("R7 busy low", c, 32'h0);
   endtask

   task automatic t_sticky;
      logic [31:0] c, x;
      pulse(1'b1, 1'b1, 4'h0);
      repeat (3) @(posedge clk);
      rd(8'h04, c, x); check("R8 eot eoc sticky", c, 32'h300);
      wr(8'h04, 32'h0);
      rd(8'h04, c, x); check("R8 write zero keeps", c, 32'h300);
      wr(8'h04, 32'h200);
      rd(8'h04, c, x); check("R8 clear eot only", c, 32'h100);
      wr(8'h04, 32'h100);
      rd(8'h04, c, x); check("R8 clear eoc", c, 32'h0);
   endtask

   task automatic t_errors;
      logic [31:0] c, x;
      pulse(1'b0, 1'b0, 4'hF);
      rd(8'h04, c, x);
      check("R9 copy error bits", c, 32'h2E);
      check("R9 xor error bits", x, 32'h20);
      wr(8'h04, 32'h2E);
      rd(8'h04, c, x); check("R9 errors cleared", c | x, 32'h0);
      pulse(1'b0, 1'b0, 4'h1);
      rd(8'h04, c, x);
      check("R9 copy split bit", c, 32'h02);
      check("R9 xor ignores split", x, 32'h00);
      wr(8'h04, 32'h02);
   endtask

   task automatic t_set_wins;
      logic [31:0] c, x;
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = 8'h04; csr_wdata = 32'h200; eng_eot = 1'b1;
      @(posedge clk); #1;
      csr_wr = 1'b0; csr_wdata = '0; eng_eot = 1'b0;
      rd(8'h04, c, x); check("R10 set beats clear", c, 32'h200);
      wr(8'h04, 32'h200);
   endtask

   task automatic t_irq;
      wr(8'h00, 32'h5);
      pulse(1'b0, 1'b1, 4'h0);
      check("R11 eoc not enabled", {31'h0, irq_c}, 32'h0);
      pulse(1'b1, 1'b0, 4'h0);
      check("R11 eot raises irq", {31'h0, irq_c}, 32'h1);
      wr(8'h04, 32'h200);
      check("R11 irq drops on clear", {31'h0, irq_c}, 32'h0);
      wr(8'h00, 32'h11);
      pulse(1'b0, 1'b0, 4'h8);
      check("R11 error irq", {30'h0, irq_c, irq_x}, 32'h3);
      wr(8'h04, 32'h120);
      check("R11 irq after error clear", {31'h0, irq_c}, 32'h0);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_undecoded;
      logic [31:0] c, x;
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      rd(8'h08, c, x); check("R12 read 0x08", c, 32'h0);
      rd(8'h24, c, x); check("R12 read 0x24", c, 32'h0);
      rd(8'h00, c, x); check("R12 ctrl untouched", c, 32'h0);
      check("R12 next untouched", nd_c, 32'hCAFE_0040);
      rd(8'h04, c, x); check("R12 status untouched", c, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_enable();
      t_resume();
      t_desc();
      t_busy();
      t_sticky();
      t_errors();
      t_set_wins();
      t_irq();
      t_undecoded();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule